// File: doc/BRIEF.md
# Segmented RAM Read Gather Unit

This block reads a run of bytes out of a RAM that is split into several parallel segment lanes, each lane holding one slice of a wide word and each with its own command and response handshakes. A requester hands over a byte address and a byte length. The block breaks the request into segment-sized words and issues one read command per word. Consecutive words go to consecutive segments in rotation. The returned words are put back in request order and leave as a byte stream. Bytes before the start address in the first word are dropped, and so are bytes after the final address in the last word.

The segments answer on their own, so one lane may return several words while another is still busy. Each lane has a small receive buffer. Command issue on a lane is held back while that lane's buffer could not take one more answer. This lets the block keep every response-ready high at all times except during pause or reset. A pause input stops new commands from being loaded and drops all response-readys. One request is handled at a time.

The segment width must be a power of two and at least two bytes. The segment count must be a power of two and at least two. The buffer depth must be at least two.

Top module: `seg_read_gather`

## Requirements
- R1: While `rst` is high, `ram_cmd_valid`, `ram_resp_ready`, `out_valid` and `req_ready` are all zero. After reset is released, `req_ready` is high.
- R2: A request (A, L) with L ≥ 1 produces exactly W = (L + A mod B + B − 1) / B segment commands, where B is the segment width in bytes. Word 0 goes to segment (A / B) mod S, where S is the segment count.
- R3: Word k goes to segment ((A / B) + k) mod S. Its command address is (A + k·B) / (S·B). Each segment lane receives its commands in increasing k.
- R4: A segment command that is valid while its ready is low stays valid with an unchanged address on the next cycle. A lane loads a new command only when it is idle or its ready is high.
- R5: `ram_resp_ready` is all ones when neither `pause` nor `rst` is high, and all zeros while `pause` is high. The block takes a response word only on a cycle where that lane's valid and ready are both high.
- R6: While `pause` is high, no lane loads a new command.
- R7: Lane s's response word is bits [s·D +: D] of `ram_resp_data`, where D is the segment data width. Within a word, byte j is bits [8j +: 8]. Output byte i equals RAM byte A + i.
- R8: Exactly L bytes are emitted. The first one is byte (A mod B) of word 0, and the last one is byte ((A + L − 1) mod B) of word W − 1. `out_last` is high on exactly the L-th byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: Output order follows word order even when lanes return their words at different rates.
- R11: Reset asserted in the middle of a transfer discards it. A new request after reset completes correctly.
- R12: `req_ready` is low from the cycle after a request is accepted until its last byte has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count, nonzero |
| pause | input | 1 | Hold off new commands and response taking |
| ram_cmd_valid | output | SEG_COUNT | Per-lane command valid |
| ram_cmd_ready | input | SEG_COUNT | Per-lane command ready |
| ram_cmd_addr | output | SEG_COUNT*SEG_ADDR_W | Per-lane word address, lane s at [s*SEG_ADDR_W +: SEG_ADDR_W] |
| ram_resp_valid | input | SEG_COUNT | Per-lane response valid |
| ram_resp_ready | output | SEG_COUNT | Per-lane response ready |
| ram_resp_data | input | SEG_COUNT*SEG_DATA_W | Per-lane response word |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the request |

## Verification
The bench covers these corner cases:

- **Single-byte request.** A design with the word count off by one would issue an extra command or never set `out_last`.
- **Start offset near the end of a word.** A design that trimmed the first word wrongly would put out shifted or extra bytes.
- **Last byte at the very top of the address space.** A wrong end offset would mark `out_last` on the wrong byte.
- **Lane 0 answering far slower than lane 1.** A design that followed arrival order instead of rotation order would interleave bytes out of sequence.
- **Command back-pressure.** A design that dropped or overwrote a waiting command would show a missing or repeated word address.
- **Pause held from the start of a request.** A command or response taken during the pause would show up at the ports.
- **Reset in the middle of a transfer.** State left over from the aborted transfer would corrupt the request that follows it.

// File: rtl/seg_read_gather.sv
module seg_read_gather #(
  parameter int SEG_COUNT  = 2,
  parameter int SEG_DATA_W = 32,
  parameter int SEG_ADDR_W = 10,
  parameter int LEN_W      = 12,
  parameter int FIFO_DEPTH = 4,
  localparam int ADDR_W = SEG_ADDR_W + $clog2(SEG_DATA_W / 8) + $clog2(SEG_COUNT)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [LEN_W-1:0]               req_len,
  input  logic                           pause,
  output logic [SEG_COUNT-1:0]           ram_cmd_valid,
  input  logic [SEG_COUNT-1:0]           ram_cmd_ready,
  output logic [SEG_COUNT*SEG_ADDR_W-1:0] ram_cmd_addr,
  input  logic [SEG_COUNT-1:0]           ram_resp_valid,
  output logic [SEG_COUNT-1:0]           ram_resp_ready,
  input  logic [SEG_COUNT*SEG_DATA_W-1:0] ram_resp_data,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [7:0]                     out_data,
  output logic                           out_last
);

  localparam int SEG_BYTES = SEG_DATA_W / 8;
  localparam int OFF_W     = $clog2(SEG_BYTES);
  localparam int SEL_W     = $clog2(SEG_COUNT);
  localparam int FP_W      = $clog2(FIFO_DEPTH);
  localparam int CNT_W     = LEN_W + 1;
  localparam int SUM_W     = LEN_W + 2;

  logic              busy;
  logic [OFF_W-1:0]  end_off, rd_byte;
  logic [CNT_W-1:0]  words, iss_cnt, rd_cnt;
  logic [SEL_W-1:0]  iss_seg, rd_seg;
  logic [ADDR_W-1:0] iss_baddr;

  logic [SEG_COUNT-1:0]  load, push, pop, fifo_has;
  logic [SEG_DATA_W-1:0] head [SEG_COUNT];
  logic [FP_W:0]         credit [SEG_COUNT];

  logic              req_fire, iss_go, out_fire, word_last, word_done;
  logic [OFF_W-1:0]  req_off, req_end, byte_stop;
  logic [SUM_W-1:0]  req_sum;
  logic [CNT_W-1:0]  req_words;
  logic [SEG_DATA_W-1:0] head_sel;

  assign req_ready = !busy && !rst;
  assign req_fire  = req_valid && req_ready;
  assign req_off   = req_addr[OFF_W-1:0];
  assign req_end   = req_off + req_len[OFF_W-1:0] - OFF_W'(1);
  assign req_sum   = SUM_W'(req_len) + SUM_W'(req_off) + SUM_W'(SEG_BYTES - 1);
  assign req_words = CNT_W'(req_sum >> OFF_W);

  assign iss_go = busy && (iss_cnt != words) && !pause &&
                  (!ram_cmd_valid[iss_seg] || ram_cmd_ready[iss_seg]) &&
                  (credit[iss_seg] != (FP_W+1)'(FIFO_DEPTH));

  assign ram_resp_ready = (rst || pause) ? '0 : '1;

  assign head_sel  = head[rd_seg];
  assign out_valid = busy && fifo_has[rd_seg];
  assign word_last = rd_cnt == words - CNT_W'(1);
  assign byte_stop = word_last ? end_off : OFF_W'(SEG_BYTES - 1);
  assign word_done = rd_byte == byte_stop;
  assign out_last  = word_last && word_done;
  assign out_data  = head_sel[{rd_byte, 3'b000} +: 8];
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      end_off   <= '0;
      rd_byte   <= '0;
      words     <= '0;
      iss_cnt   <= '0;
      rd_cnt    <= '0;
      iss_seg   <= '0;
      rd_seg    <= '0;
      iss_baddr <= '0;
    end else if (req_fire) begin
      busy      <= 1'b1;
      end_off   <= req_end;
      rd_byte   <= req_off;
      words     <= req_words;
      iss_cnt   <= '0;
      rd_cnt    <= '0;
      iss_seg   <= req_addr[OFF_W +: SEL_W];
      rd_seg    <= req_addr[OFF_W +: SEL_W];
      iss_baddr <= req_addr;
    end else begin
      if (iss_go) begin
        iss_cnt   <= iss_cnt + CNT_W'(1);
        iss_seg   <= iss_seg + SEL_W'(1);
        iss_baddr <= iss_baddr + ADDR_W'(SEG_BYTES);
      end
      if (out_fire) begin
        if (word_done) begin
          rd_byte <= '0;
          rd_seg  <= rd_seg + SEL_W'(1);
          rd_cnt  <= rd_cnt + CNT_W'(1);
          if (word_last) busy <= 1'b0;
        end else begin
          rd_byte <= rd_byte + OFF_W'(1);
        end
      end
    end
  end

  for (genvar s = 0; s < SEG_COUNT; s++) begin : g_lane
    logic                  cv;
    logic [SEG_ADDR_W-1:0] ca;
    logic [SEG_DATA_W-1:0] mem [FIFO_DEPTH];
    logic [FP_W:0]         wp, rp, cr;

    assign load[s] = iss_go && (iss_seg == SEL_W'(s));
    assign push[s] = ram_resp_valid[s] && ram_resp_ready[s];
    assign pop[s]  = out_fire && word_done && (rd_seg == SEL_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        cv <= 1'b0;
        ca <= '0;
      end else if (load[s]) begin
        cv <= 1'b1;
        ca <= iss_baddr[ADDR_W-1 -: SEG_ADDR_W];
      end else if (ram_cmd_ready[s]) begin
        cv <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wp <= '0;
        rp <= '0;
        cr <= '0;
      end else begin
        if (push[s]) wp <= wp + (FP_W+1)'(1);
        if (pop[s])  rp <= rp + (FP_W+1)'(1);
        cr <= cr + (FP_W+1)'(load[s]) - (FP_W+1)'(pop[s]);
      end
    end

    always_ff @(posedge clk) begin
      if (push[s]) mem[wp[FP_W-1:0]] <= ram_resp_data[s*SEG_DATA_W +: SEG_DATA_W];
    end

    assign ram_cmd_valid[s] = cv;
    assign ram_cmd_addr[s*SEG_ADDR_W +: SEG_ADDR_W] = ca;
    assign fifo_has[s] = wp != rp;
    assign head[s]     = mem[rp[FP_W-1:0]];
    assign credit[s]   = cr;
  end

endmodule

// File: rtl/seg_read_gather_chk.sv
module seg_read_gather_chk #(
  parameter int SEG_COUNT  = 2,
  parameter int SEG_DATA_W = 32,
  parameter int SEG_ADDR_W = 10,
  parameter int LEN_W      = 12,
  parameter int FIFO_DEPTH = 4,
  localparam int ADDR_W = SEG_ADDR_W + $clog2(SEG_DATA_W / 8) + $clog2(SEG_COUNT)
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            req_valid,
  input logic                            req_ready,
  input logic [ADDR_W-1:0]               req_addr,
  input logic [LEN_W-1:0]                req_len,
  input logic                            pause,
  input logic [SEG_COUNT-1:0]            ram_cmd_valid,
  input logic [SEG_COUNT-1:0]            ram_cmd_ready,
  input logic [SEG_COUNT*SEG_ADDR_W-1:0] ram_cmd_addr,
  input logic [SEG_COUNT-1:0]            ram_resp_valid,
  input logic [SEG_COUNT-1:0]            ram_resp_ready,
  input logic [SEG_COUNT*SEG_DATA_W-1:0] ram_resp_data,
  input logic                            out_valid,
  input logic                            out_ready,
  input logic [7:0]                      out_data,
  input logic                            out_last
);

  for (genvar s = 0; s < SEG_COUNT; s++) begin : g_chk
    a_r4_cmd_hold: assert property (@(posedge clk) disable iff (rst)
      ram_cmd_valid[s] && !ram_cmd_ready[s] |=>
        ram_cmd_valid[s] && $stable(ram_cmd_addr[s*SEG_ADDR_W +: SEG_ADDR_W]));

    a_r6_pause_no_load: assert property (@(posedge clk) disable iff (rst)
      pause && (!ram_cmd_valid[s] || ram_cmd_ready[s]) |=> !ram_cmd_valid[s]);
  end

  a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r12_one_at_a_time: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  a_r12_idle_before_accept: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !out_valid);

endmodule

bind seg_read_gather seg_read_gather_chk #(
  .SEG_COUNT(SEG_COUNT), .SEG_DATA_W(SEG_DATA_W), .SEG_ADDR_W(SEG_ADDR_W),
  .LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH)
) chk_i (.*);

// File: tb/seg_read_gather_tb_top.sv
module seg_read_gather_tb_top;
  localparam int SC = 2;
  localparam int DW = 32;
  localparam int AW_SEG = 10;
  localparam int LW = 12;
  localparam int SB = DW / 8;
  localparam int BUS = SC * SB;
  localparam int AW = AW_SEG + $clog2(SB) + $clog2(SC);

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic pause = 1'b0;
  logic [SC-1:0] ram_cmd_valid, ram_cmd_ready, ram_resp_valid, ram_resp_ready;
  logic [SC*AW_SEG-1:0] ram_cmd_addr;
  logic [SC*DW-1:0] ram_resp_data;
  logic out_valid, out_ready, out_last;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  seg_read_gather #(.SEG_COUNT(SC), .SEG_DATA_W(DW), .SEG_ADDR_W(AW_SEG), .LEN_W(LW), .FIFO_DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .pause(pause), .ram_cmd_valid(ram_cmd_valid), .ram_cmd_ready(ram_cmd_ready),
    .ram_cmd_addr(ram_cmd_addr), .ram_resp_valid(ram_resp_valid), .ram_resp_ready(ram_resp_ready),
    .ram_resp_data(ram_resp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last));

  int nchk = 0, nfail = 0;
  int cyc = 0;
  bit bp_cmd = 0, bp_out = 0, slow0 = 0, active = 0;
  int exp_addr, exp_len, exp_words, first_seg, got, ncmd, nlast;
  int nk [SC];
  int q [SC][16];
  int qw [SC], qr [SC];
  bit took [SC];

  function automatic logic [7:0] mem_byte(int a);
    return 8'((a * 29) ^ (a >> 4));
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // RAM lanes and output sink, all acting at the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    if (rst) begin
      for (int s = 0; s < SC; s++) begin
        qw[s] = 0; qr[s] = 0; took[s] = 0;
        ram_resp_valid[s] = 1'b0;
        ram_cmd_ready[s] = 1'b0;
      end
      ram_resp_data = '0;
      out_ready = 1'b0;
    end else begin
      for (int s = 0; s < SC; s++) begin
        ram_cmd_ready[s] = bp_cmd ? ((cyc + s) % 3 != 0) : 1'b1;
        if (!(ram_resp_valid[s] && !took[s])) begin
          if (qw[s] != qr[s] && (!slow0 || s != 0 || cyc % 6 == 0)) begin
            ram_resp_valid[s] = 1'b1;
            for (int j = 0; j < SB; j++)
              ram_resp_data[s*DW + j*8 +: 8] = mem_byte(q[s][qr[s] % 16] * BUS + s * SB + j);
          end else begin
            ram_resp_valid[s] = 1'b0;
          end
        end
      end
      out_ready = bp_out ? (cyc % 4 != 1) : 1'b1;
    end
    #1;
    if (!rst) begin
      for (int s = 0; s < SC; s++) begin
        took[s] = ram_resp_valid[s] && ram_resp_ready[s];
        if (took[s]) qr[s]++;
        if (ram_cmd_valid[s] && ram_cmd_ready[s]) begin
          int k, ea, aa;
          k = ((s - first_seg + SC) % SC) + nk[s] * SC;
          ea = (exp_addr + k * SB) / BUS;
          aa = int'(ram_cmd_addr[s*AW_SEG +: AW_SEG]);
          check(active && k < exp_words, "R2", "command beyond word count", k, exp_words);
          check(aa == ea, "R3", "command address", aa, ea);
          q[s][qw[s] % 16] = aa;
          qw[s]++;
          nk[s]++;
          ncmd++;
        end
      end
      if (out_valid && out_ready) begin
        check(active && got < exp_len, "R8", "byte beyond length", got, exp_len);
        check(out_data == mem_byte(exp_addr + got), "R7", "output byte", out_data, mem_byte(exp_addr + got));
        check(out_last == (got == exp_len - 1), "R8", "last flag", out_last, got == exp_len - 1);
        if (out_last) nlast++;
        got++;
      end
    end
  end

  task automatic start_req(int a, int l);
    @(negedge clk);
    exp_addr = a; exp_len = l; got = 0; ncmd = 0; nlast = 0;
    exp_words = (l + a % SB + SB - 1) / SB;
    first_seg = (a / SB) % SC;
    for (int s = 0; s < SC; s++) nk[s] = 0;
    active = 1;
    req_addr = AW'(a); req_len = LW'(l); req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(req_ready == 1'b0, "R12", "req_ready while busy", req_ready, 0);
  endtask

  task automatic wait_done(string tag);
    int t = 0;
    while (!(got == exp_len && req_ready) && t < 5000) begin @(negedge clk); #2; t++; end
    check(t < 5000, "R8", {tag, " completion"}, t, 5000);
    check(got == exp_len, "R8", {tag, " byte count"}, got, exp_len);
    check(nlast == 1, "R8", {tag, " last count"}, nlast, 1);
    check(ncmd == exp_words, "R2", {tag, " command count"}, ncmd, exp_words);
    active = 0;
  endtask

  task automatic run_xfer(int a, int l, string tag);
    start_req(a, l);
    wait_done(tag);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(ram_cmd_valid == '0, "R1", "cmd valid in reset", ram_cmd_valid, 0);
    check(ram_resp_ready == '0, "R1", "resp ready in reset", ram_resp_ready, 0);
    check(out_valid == 1'b0, "R1", "out valid in reset", out_valid, 0);
    check(req_ready == 1'b0, "R1", "req ready in reset", req_ready, 0);
    rst = 1'b0;
    @(negedge clk); #1;
    check(req_ready == 1'b1, "R1", "req ready after reset", req_ready, 1);
    check(ram_resp_ready == '1, "R5", "resp ready idle", ram_resp_ready, 3);
  endtask

  task automatic t_basic;
    run_xfer('h100, 16, "R3 aligned");
  endtask

  task automatic t_offsets;
    run_xfer('h105, 1, "R2 single byte seg1");
    run_xfer('h10B, 3, "R8 offset3 crossing");
    run_xfer('h202, 7, "R8 mid offsets");
    run_xfer('h3FD, 20, "R7 odd start");
    run_xfer('h007, 100, "R3 long");
    run_xfer('h1FF3, 13, "R8 top of space");
  endtask

  task automatic t_backpressure;
    bp_cmd = 1; bp_out = 1;
    run_xfer('h233, 57, "R4 R9 backpressure");
    bp_cmd = 0; bp_out = 0;
  endtask

  task automatic t_skew;
    slow0 = 1;
    run_xfer('h400, 64, "R10 slow lane0");
    run_xfer('h605, 30, "R10 slow lane0 offset");
    bp_out = 1;
    run_xfer('h0E1, 45, "R10 slow lane0 out bp");
    bp_out = 0; slow0 = 0;
  endtask

  task automatic t_pause;
    @(negedge clk);
    pause = 1'b1;
    start_req('h520, 24);
    repeat (6) begin
      @(negedge clk); #1;
      check(ram_cmd_valid == '0, "R6", "command during pause", ram_cmd_valid, 0);
      check(ram_resp_ready == '0, "R5", "resp ready during pause", ram_resp_ready, 0);
    end
    pause = 1'b0;
    #1;
    check(ram_resp_ready == '1, "R5", "resp ready after pause", ram_resp_ready, 3);
    wait_done("R6 paused start");
  endtask

  task automatic t_midreset;
    bp_out = 1;
    start_req('h040, 200);
    repeat (12) @(negedge clk);
    active = 0;
    rst = 1'b1;
    @(negedge clk); #1;
    check(ram_cmd_valid == '0, "R11", "cmd valid after abort", ram_cmd_valid, 0);
    check(out_valid == 1'b0, "R11", "out valid after abort", out_valid, 0);
    check(ram_resp_ready == '0, "R11", "resp ready in abort", ram_resp_ready, 0);
    rst = 1'b0;
    bp_out = 0;
    run_xfer('h046, 21, "R11 after abort");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_offsets();
    t_backpressure();
    t_skew();
    t_pause();
    t_midreset();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule